// File: doc/BRIEF.md
# Device Endpoint-Zero Control Register

This block is the control and status register for the default control endpoint of a device-side serial bus controller. A CPU port writes and reads one 8-bit register. The register holds three kinds of bit. Some are flags that only hardware sets, and the CPU can only read them. Some are read/write requests that hardware clears by itself. Two are write-one strobes that clear the read-only flags.

The protocol engine reports five kinds of event to the block:
- a data packet was received;
- an IN packet was acknowledged;
- a STALL handshake was sent;
- a SETUP token arrived before the data phase had finished;
- the control transfer finished.

The block drives the transmit-ready and send-stall requests back to the engine. It also drives the data-end flag and a one-cycle endpoint interrupt pulse.

Every piece of state and every output is a flop. A stimulus applied in one cycle appears on all outputs just after the next rising clock edge. Packet encoding, FIFOs and request decoding are outside this block.

Top module: `ep0_ctrl_reg`

## Requirements
- R1: After a synchronous reset, every register bit, `ep_irq`, `tx_ready`, `send_stall` and `data_end` are 0.
- R2: The read value `cpu_rdata` is laid out as follows: [7] and [6] always read 0, [5] send-stall, [4] setup-end, [3] data-end, [2] stalled, [1] transmit-ready, [0] receive-ready.
- R3: A write with bit 7 = 1 clears setup-end, and a write with bit 6 = 1 clears receive-ready. A 0 in either bit leaves the flag unchanged.
- R4: Setup-end (bit 4) and receive-ready (bit 0) cannot be written by the CPU. Write data in those positions is ignored.
- R5: Send-stall is loaded from write bit 5. It clears in the cycle after `ev_stall_sent`. If a write and `ev_stall_sent` occur in the same cycle, the clear wins.
- R6: `ev_stall_sent` sets stalled. Stalled holds until a write with bit 2 = 0. If a write and `ev_stall_sent` occur in the same cycle, the set wins.
- R7: `ev_setup_early` sets setup-end only while data-end reads 0. While data-end reads 1, the event is ignored.
- R8: Transmit-ready is loaded from write bit 1 and cleared by `ev_in_acked`. If both occur in the same cycle, the clear wins.
- R9: Data-end is loaded from write bit 3. It is cleared by `ev_in_acked` or `ev_xfer_done`, and the clear wins over a write in the same cycle.
- R10: `ep_irq` is high for exactly the one cycle after any of these causes, and is low in every other cycle:
  - `ev_rx_pkt`;
  - an `ev_setup_early` that sets setup-end;
  - a write of 1 to bit 1 while transmit-ready reads 0.
- R11: `ev_rx_pkt` sets receive-ready, and a hardware set wins over a clear strobe that arrives in the same cycle. The same rule applies to `ev_setup_early` and setup-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read value |
| ev_rx_pkt | input | 1 | Engine received a data packet |
| ev_in_acked | input | 1 | Engine's IN packet was acknowledged |
| ev_stall_sent | input | 1 | Engine transmitted a STALL handshake |
| ev_setup_early | input | 1 | New SETUP arrived before the data phase ended |
| ev_xfer_done | input | 1 | Control transfer finished |
| tx_ready | output | 1 | Transmit-ready request to engine |
| send_stall | output | 1 | Send-stall request to engine |
| data_end | output | 1 | Data-end flag |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
Every result in this block is due exactly one rising edge after its stimulus: register bits, request outputs and the interrupt pulse all come from flops loaded on the edge that samples the write or event. The bench drives each stimulus on a falling edge and removes it just after the next rising edge. It then compares the read value and all four outputs against a bench model that was stepped once with the same inputs. Directed same-cycle collisions between sets, clears and writes check the priority rules. Random cycles then mix all events and writes.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int REG_W   = 8;
  localparam int STATE_W = 6;
  // state bit positions, equal to their read positions
  localparam int B_RXRDY = 0;
  localparam int B_TXRDY = 1;
  localparam int B_STLD  = 2;
  localparam int B_DEND  = 3;
  localparam int B_SEND  = 4;
  localparam int B_STALL = 5;
  // strobe positions in write data
  localparam int W_CLR_RX = 6;
  localparam int W_CLR_SE = 7;
  // bits whose hardware set beats every clear and load
  localparam logic [STATE_W-1:0] SET_WINS_MASK =
    (STATE_W'(1) << B_RXRDY) | (STATE_W'(1) << B_STLD) | (STATE_W'(1) << B_SEND);

  typedef struct packed {
    logic rx_pkt;
    logic in_acked;
    logic stall_sent;
    logic setup_early;
    logic xfer_done;
  } ep0_evt_t;
endpackage

// File: rtl/ep0_bit_cell.sv
module ep0_bit_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic load_i,
  input  logic load_val_i,
  output logic q_o
);
  logic q_next;

  generate
    if (SET_WINS) begin : g_set_first
      always_comb begin
        if (set_i)       q_next = 1'b1;
        else if (clr_i)  q_next = 1'b0;
        else if (load_i) q_next = load_val_i;
        else             q_next = q_o;
      end
      AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o); // R11
    end else begin : g_clr_first
      always_comb begin
        if (clr_i)       q_next = 1'b0;
        else if (set_i)  q_next = 1'b1;
        else if (load_i) q_next = load_val_i;
        else             q_next = q_o;
      end
      AST_CLR_DOMINATES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o); // R8
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= q_next;
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |src_i;
  end
endmodule

// File: rtl/ep0_ctrl_reg.sv
module ep0_ctrl_reg
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             ev_rx_pkt,
  input  logic             ev_in_acked,
  input  logic             ev_stall_sent,
  input  logic             ev_setup_early,
  input  logic             ev_xfer_done,
  output logic             tx_ready,
  output logic             send_stall,
  output logic             data_end,
  output logic             ep_irq
);
  localparam int PAD_W   = REG_W - STATE_W;
  localparam int N_IRQ   = 3;

  ep0_evt_t             evt;
  logic [STATE_W-1:0]   st_q;
  logic [STATE_W-1:0]   set_v, clr_v, load_v, lval_v;
  logic                 setend_hit;
  logic [N_IRQ-1:0]     irq_src;

  assign evt = '{rx_pkt: ev_rx_pkt, in_acked: ev_in_acked, stall_sent: ev_stall_sent,
                 setup_early: ev_setup_early, xfer_done: ev_xfer_done};

  // early SETUP only counts while data-end is clear (R7)
  assign setend_hit = evt.setup_early && !st_q[B_DEND];

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    load_v = '0;
    lval_v = cpu_wdata[STATE_W-1:0];
    // read-only flags: hardware set, strobe clear (R3, R4, R11)
    set_v[B_RXRDY]  = evt.rx_pkt;
    clr_v[B_RXRDY]  = cpu_wr && cpu_wdata[W_CLR_RX];
    set_v[B_SEND]   = setend_hit;
    clr_v[B_SEND]   = cpu_wr && cpu_wdata[W_CLR_SE];
    // stalled: hardware set, software load (R6)
    set_v[B_STLD]   = evt.stall_sent;
    load_v[B_STLD]  = cpu_wr;
    // self-clearing requests (R5, R8, R9)
    load_v[B_TXRDY] = cpu_wr;
    clr_v[B_TXRDY]  = evt.in_acked;
    load_v[B_DEND]  = cpu_wr;
    clr_v[B_DEND]   = evt.in_acked || evt.xfer_done;
    load_v[B_STALL] = cpu_wr;
    clr_v[B_STALL]  = evt.stall_sent;
  end

  generate
    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
      ep0_bit_cell #(.SET_WINS(SET_WINS_MASK[i])) u_cell (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_v[i]),
        .clr_i      (clr_v[i]),
        .load_i     (load_v[i]),
        .load_val_i (lval_v[i]),
        .q_o        (st_q[i])
      );
    end
  endgenerate

  // interrupt causes (R10)
  assign irq_src = {evt.rx_pkt, setend_hit, cpu_wr && cpu_wdata[B_TXRDY] && !st_q[B_TXRDY]};

  ep0_irq_gen #(.N_SRC(N_IRQ)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .src_i (irq_src),
    .irq_o (ep_irq)
  );

  assign cpu_rdata  = {{PAD_W{1'b0}}, st_q}; // R2
  assign tx_ready   = st_q[B_TXRDY];
  assign send_stall = st_q[B_STALL];
  assign data_end   = st_q[B_DEND];

  AST_STALL_SELF_CLR: assert property (@(posedge clk) disable iff (rst)
    ev_stall_sent |=> (!send_stall && cpu_rdata[B_STLD])); // R5
  AST_RX_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rdata[B_RXRDY]) |-> $past(ev_rx_pkt)); // R4
  AST_SETEND_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rdata[B_SEND]) |-> ep_irq); // R10
  AST_SETEND_NEEDS_NO_DEND: assert property (@(posedge clk) disable iff (rst)
    (ev_setup_early && data_end && !cpu_rdata[B_SEND]) |=> !cpu_rdata[B_SEND]); // R7
  AST_DEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (ev_in_acked || ev_xfer_done) |=> !data_end); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (cpu_rdata == '0 && !ep_irq)); // R1
endmodule

// File: tb/ep0_ctrl_reg_tb_top.sv
module ep0_ctrl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_wr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       ev_rx_pkt, ev_in_acked, ev_stall_sent, ev_setup_early, ev_xfer_done;
  logic       tx_ready, send_stall, data_end, ep_irq;

  int n_checks = 0;
  int n_errors = 0;
  logic [5:0] m_st;
  logic       m_irq;
  int unsigned seed = 32'd7411;

  always #2.5 clk = ~clk;

  ep0_ctrl_reg dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ev_rx_pkt(ev_rx_pkt), .ev_in_acked(ev_in_acked), .ev_stall_sent(ev_stall_sent),
    .ev_setup_early(ev_setup_early), .ev_xfer_done(ev_xfer_done),
    .tx_ready(tx_ready), .send_stall(send_stall), .data_end(data_end), .ep_irq(ep_irq)
  );

  // spec model: bits [5]stall [4]setend [3]dend [2]stalled [1]txrdy [0]rxrdy
  function automatic logic [5:0] model_next(logic [5:0] s, logic wr, logic [7:0] wd,
      logic rx, logic ack, logic ss, logic se, logic xd);
    logic [5:0] n = s;
    if (wr) begin
      n[5] = wd[5]; n[3] = wd[3]; n[2] = wd[2]; n[1] = wd[1];
      if (wd[7]) n[4] = 1'b0;
      if (wd[6]) n[0] = 1'b0;
    end
    if (rx) n[0] = 1'b1;
    if (se && !s[3]) n[4] = 1'b1;
    if (ss) begin n[2] = 1'b1; n[5] = 1'b0; end
    if (ack) begin n[1] = 1'b0; n[3] = 1'b0; end
    if (xd) n[3] = 1'b0;
    return n;
  endfunction

  function automatic logic model_irq(logic [5:0] s, logic wr, logic [7:0] wd, logic rx, logic se);
    return rx || (se && !s[3]) || (wr && wd[1] && !s[1]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic wr, logic [7:0] wd, logic rx, logic ack, logic ss, logic se, logic xd);
    @(negedge clk);
    cpu_wr = wr; cpu_wdata = wd; ev_rx_pkt = rx; ev_in_acked = ack;
    ev_stall_sent = ss; ev_setup_early = se; ev_xfer_done = xd;
    m_irq = model_irq(m_st, wr, wd, rx, se);
    m_st  = model_next(m_st, wr, wd, rx, ack, ss, se, xd);
    @(posedge clk);
    #1;
    cpu_wr = 0; cpu_wdata = '0; ev_rx_pkt = 0; ev_in_acked = 0;
    ev_stall_sent = 0; ev_setup_early = 0; ev_xfer_done = 0;
    chk("R2 read value", cpu_rdata, {2'b00, m_st});
    chk("R10 interrupt", {7'd0, ep_irq}, {7'd0, m_irq});
    chk("R8 tx_ready", {7'd0, tx_ready}, {7'd0, m_st[1]});
    chk("R5 send_stall", {7'd0, send_stall}, {7'd0, m_st[5]});
    chk("R9 data_end", {7'd0, data_end}, {7'd0, m_st[3]});
  endtask

  initial begin
    #(5 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1; cpu_wr = 0; cpu_wdata = '0; ev_rx_pkt = 0; ev_in_acked = 0;
    ev_stall_sent = 0; ev_setup_early = 0; ev_xfer_done = 0; m_st = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 reset read", cpu_rdata, 8'h00);
    chk("R1 reset outputs", {4'd0, tx_ready, send_stall, data_end, ep_irq}, 8'h00);
    // R4: write all ones, read-only flags ignore data, strobes clear nothing
    cyc(1, 8'hFF, 0, 0, 0, 0, 0);
    chk("R4 ro flags", cpu_rdata, 8'h2E);
    cyc(0, 0, 0, 0, 1, 0, 0);                    // R5 self-clear, R6 stalled stays
    chk("R6 stalled", {7'd0, cpu_rdata[2]}, 8'h01);
    cyc(0, 0, 0, 0, 0, 1, 0);                    // R7 ignored while data-end set
    chk("R7 setend held off", {7'd0, cpu_rdata[4]}, 8'h00);
    cyc(0, 0, 0, 1, 0, 0, 0);                    // R8/R9 cleared by ack
    cyc(0, 0, 0, 0, 0, 1, 0);                    // R7 sets setup-end and irq
    chk("R7 setend set", {7'd0, cpu_rdata[4]}, 8'h01);
    cyc(1, 8'h80, 0, 0, 0, 1, 0);                // R11 set beats strobe
    chk("R11 setend set wins", {7'd0, cpu_rdata[4]}, 8'h01);
    cyc(1, 8'h80, 0, 0, 0, 0, 0);                // R3 strobe clears
    chk("R3 setend clear", {7'd0, cpu_rdata[4]}, 8'h00);
    cyc(0, 0, 1, 0, 0, 0, 0);                    // R10 rx irq
    cyc(1, 8'h00, 0, 0, 0, 0, 0);                // R3 zero strobe no effect
    chk("R3 zero strobe", {7'd0, cpu_rdata[0]}, 8'h01);
    cyc(1, 8'h40, 1, 0, 0, 0, 0);                // R11 rx set wins
    cyc(1, 8'h40, 0, 0, 0, 0, 0);                // R3 rx clear
    chk("R3 rx clear", {7'd0, cpu_rdata[0]}, 8'h00);
    cyc(1, 8'h20, 0, 0, 1, 0, 0);                // R5 clear wins, R6 set wins
    cyc(1, 8'h00, 0, 0, 0, 0, 0);                // R6 software clears stalled
    chk("R6 stalled cleared", {7'd0, cpu_rdata[2]}, 8'h00);
    cyc(1, 8'h08, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);                    // R9 transfer end clears data-end
    cyc(1, 8'h02, 0, 1, 0, 0, 0);                // R8 ack wins, irq still pulses
    cyc(0, 0, 0, 0, 0, 0, 0);                    // R10 pulse lasts one cycle
    for (int i = 0; i < 3000; i++) begin
      logic wr = (($urandom(seed) & 3) == 0);
      seed = seed + 32'd1;
      cyc(wr, 8'($urandom()), ($urandom() & 7) == 0, ($urandom() & 7) == 0,
          ($urandom() & 7) == 0, ($urandom() & 7) == 0, ($urandom() & 15) == 0);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule